// File: doc/BRIEF.md
# Vector Address Generation Unit

This block turns two vector operands into a vector of addresses in one pipelined step. Every lane adds an element of the base vector to an element of the offset vector, with the offset first scaled by a left shift of zero to three places. A 32-bit instruction word, presented with the operands, decides how the vector is carved into lanes and how the offset is widened. It also carries the scale and three register numbers.

The instruction word, both operands and an input strobe arrive together. One clock later the block presents the address vector with a result strobe, along with the decoded register numbers. If the strobed word is not an address-generation instruction, the block raises an illegal flag for that cycle instead, and the previous result stays on the outputs. The vector width is a parameter and must be a multiple of 64 bits. Every lane is computed at once.

Top module: `vector_addr_gen`

## Requirements
- R1: A word is recognised only when bits 31:24 are 8'b00000100, bit 21 is 1 and bits 15:12 are 4'b1010; no other word produces a result.
- R2: Bits 23:22 pick the mode: 2'b10 gives independent 32-bit lanes, 2'b11 gives 64-bit lanes, and 2'b00 or 2'b01 give 64-bit lanes with a 32-bit offset that is sign-extended or zero-extended.
- R3: The scale comes from bits 11:10. The offset register number (bits 20:16), base register number (bits 9:5) and destination register number (bits 4:0) appear on outRm, outRn and outRd with the result.
- R4: With 32-bit lanes, each 32-bit slice of the result is the base slice plus the scaled offset slice, taken modulo 2^32. No carry crosses into the neighbouring slice.
- R5: With 64-bit lanes, each 64-bit slice of the result is the base slice plus the scaled offset slice, taken modulo 2^64.
- R6: In mode 2'b00, only bits 31:0 of each 64-bit offset slice are used. They are sign-extended to 64 bits, shifted, and added modulo 2^64.
- R7: In mode 2'b01, bits 31:0 of each 64-bit offset slice are zero-extended to 64 bits, shifted, and added modulo 2^64. Bits 63:32 of the offset have no effect.
- R8: The offset is shifted left by 0 to 3 places. Bits shifted past the top of a lane are discarded.
- R9: outValid is 1 in the cycle after inValid is sampled high with a recognised word, and outIllegal is 0 in that cycle.
- R10: When inValid is sampled high with an unrecognised word, the next cycle has outIllegal at 1 and outValid at 0, and outVec, outRd, outRn and outRm keep their previous values.
- R11: While rst is high at a clock edge (synchronous, active high), outValid and outIllegal are cleared.
- R12: When inValid is sampled low, the next cycle has outValid and outIllegal both at 0, and the result and register outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Strobe qualifying instr and both operands |
| instr | input | 32 | Instruction word |
| baseVec | input | VEC_W | Base operand vector |
| offsVec | input | VEC_W | Offset operand vector |
| outValid | output | 1 | Result strobe, one cycle after a recognised word |
| outIllegal | output | 1 | Unrecognised word flag, one cycle after the strobe |
| outRd | output | 5 | Destination register number of the last result |
| outRn | output | 5 | Base register number of the last result |
| outRm | output | 5 | Offset register number of the last result |
| outVec | output | VEC_W | Address vector of the last result |

## Verification
Two things can meet in a single cycle. One is a result being loaded from a recognised word. The other is the retire of the previous operation, whether that was a result or an illegal word. Back-to-back strobes provoke this meeting, with recognised and unrecognised words interleaved and mode switches from one cycle to the next. A behavioural model in the bench decides what every output should be in each of those cycles, so it can tell whether the flags from the old operation and the data from the new one line up. A second meeting happens inside each lane: carries and shifted-out bits sit on a lane boundary. All-ones operands drive these cases, and the bench judges them by lane-wise modular arithmetic.

// File: rtl/vag_pkg.sv
package vag_pkg;

  localparam logic [7:0] OPC_HIGH = 8'b00000100;
  localparam logic [3:0] OPC_MID  = 4'b1010;

  typedef enum logic [1:0] {
    VAR_S32 = 2'b00,
    VAR_U32 = 2'b01,
    VAR_P32 = 2'b10,
    VAR_P64 = 2'b11
  } addrVariant_e;

  typedef struct packed {
    logic         load;
    logic         illegal;
    addrVariant_e variant;
    logic [1:0]   shiftAmt;
    logic [4:0]   rd;
    logic [4:0]   rn;
    logic [4:0]   rm;
  } ctrlStrobes_t;

endpackage

// File: rtl/vag_lane64.sv
module vag_lane64
  import vag_pkg::*;
(
  input  addrVariant_e variant,
  input  logic [1:0]   shiftAmt,
  input  logic [63:0]  baseIn,
  input  logic [63:0]  offsIn,
  output logic [63:0]  sumOut
);

  logic [63:0] offExt;
  logic [63:0] wideSum;
  logic [31:0] loSum;
  logic [31:0] hiSum;

  always_comb begin
    unique case (variant)
      VAR_S32: offExt = {{32{offsIn[31]}}, offsIn[31:0]};
      VAR_U32: offExt = {32'b0, offsIn[31:0]};
      default: offExt = offsIn;
    endcase
  end

  // 64-bit lane path: extension already applied, wrap at 64 bits
  assign wideSum = baseIn + (offExt << shiftAmt);

  // two independent 32-bit lanes: each wraps on its own
  assign loSum = baseIn[31:0]  + (offsIn[31:0]  << shiftAmt);
  assign hiSum = baseIn[63:32] + (offsIn[63:32] << shiftAmt);

  assign sumOut = (variant == VAR_P32) ? {hiSum, loSum} : wideSum;

endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [31:0]  instr,
  output ctrlStrobes_t strobes,
  output logic         validQ,
  output logic         illegalQ
);

  logic isMatch;

  assign isMatch = (instr[31:24] == OPC_HIGH) && instr[21] && (instr[15:12] == OPC_MID);

  always_comb begin
    strobes.load     = inValid && isMatch;
    strobes.illegal  = inValid && !isMatch;
    strobes.variant  = addrVariant_e'(instr[23:22]);
    strobes.shiftAmt = instr[11:10];
    strobes.rm       = instr[20:16];
    strobes.rn       = instr[9:5];
    strobes.rd       = instr[4:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      validQ   <= strobes.load;
      illegalQ <= strobes.illegal;
    end
  end

endmodule

// File: rtl/vag_datapath.sv
module vag_datapath
  import vag_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  ctrlStrobes_t       strobes,
  input  logic [VEC_W-1:0]   baseVec,
  input  logic [VEC_W-1:0]   offsVec,
  output logic [VEC_W-1:0]   vecQ,
  output logic [4:0]         rdQ,
  output logic [4:0]         rnQ,
  output logic [4:0]         rmQ
);

  localparam int SLICES = VEC_W / 64;

  logic [VEC_W-1:0] sumVec;

  for (genvar g = 0; g < SLICES; g++) begin : gSlice
    vag_lane64 uLane (
      .variant  (strobes.variant),
      .shiftAmt (strobes.shiftAmt),
      .baseIn   (baseVec[g*64 +: 64]),
      .offsIn   (offsVec[g*64 +: 64]),
      .sumOut   (sumVec[g*64 +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      vecQ <= sumVec;
      rdQ  <= strobes.rd;
      rnQ  <= strobes.rn;
      rmQ  <= strobes.rm;
    end
  end

endmodule

// File: rtl/vector_addr_gen.sv
module vector_addr_gen
  import vag_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] baseVec,
  input  logic [VEC_W-1:0] offsVec,
  output logic             outValid,
  output logic             outIllegal,
  output logic [4:0]       outRd,
  output logic [4:0]       outRn,
  output logic [4:0]       outRm,
  output logic [VEC_W-1:0] outVec
);

  ctrlStrobes_t strobes;

  vag_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .instr    (instr),
    .strobes  (strobes),
    .validQ   (outValid),
    .illegalQ (outIllegal)
  );

  vag_datapath #(.VEC_W(VEC_W)) uData (
    .clk     (clk),
    .strobes (strobes),
    .baseVec (baseVec),
    .offsVec (offsVec),
    .vecQ    (outVec),
    .rdQ     (outRd),
    .rnQ     (outRn),
    .rmQ     (outRm)
  );

endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [31:0]      instr,
  input logic [VEC_W-1:0] baseVec,
  input logic [VEC_W-1:0] offsVec,
  input logic             outValid,
  input logic             outIllegal,
  input logic [4:0]       outRd,
  input logic [4:0]       outRn,
  input logic [4:0]       outRm,
  input logic [VEC_W-1:0] outVec
);

  logic wordOk;
  assign wordOk = (instr[31:24] == 8'h04) && instr[21] && (instr[15:12] == 4'hA);

  p_result_next_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && wordOk) |=> (outValid && !outIllegal));

  p_illegal_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && !wordOk) |=> (outIllegal && !outValid && $stable(outVec) && $stable(outRd)));

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outIllegal && $stable(outVec)));

  p_reg_fields_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && wordOk) |=> (outRd == $past(instr[4:0]) && outRn == $past(instr[9:5])
                             && outRm == $past(instr[20:16])));

  p_wide_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && wordOk && instr[23:22] == 2'b11) |=>
      (outVec[63:0] == $past(baseVec[63:0] + (offsVec[63:0] << instr[11:10]))));

  p_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && wordOk && instr[23:22] == 2'b01) |=>
      (outVec[63:0] == $past(baseVec[63:0] + ({32'b0, offsVec[31:0]} << instr[11:10]))));

  p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outIllegal));

endmodule

bind vector_addr_gen vag_checker #(.VEC_W(VEC_W)) uChecker (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .instr      (instr),
  .baseVec    (baseVec),
  .offsVec    (offsVec),
  .outValid   (outValid),
  .outIllegal (outIllegal),
  .outRd      (outRd),
  .outRn      (outRn),
  .outRm      (outRm),
  .outVec     (outVec)
);

// File: tb/vector_addr_gen_test.sv
module vector_addr_gen_test;

  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VW-1:0] baseVec = '0;
  logic [VW-1:0] offsVec = '0;
  logic          outValid, outIllegal;
  logic [4:0]    outRd, outRn, outRm;
  logic [VW-1:0] outVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  bit            expValid, expIll, haveData;
  logic [VW-1:0] expVec;
  logic [4:0]    expRd, expRn, expRm;

  always #5 clk = ~clk;

  vector_addr_gen #(.VEC_W(VW)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .baseVec(baseVec), .offsVec(offsVec),
    .outValid(outValid), .outIllegal(outIllegal),
    .outRd(outRd), .outRn(outRn), .outRm(outRm), .outVec(outVec)
  );

  function automatic logic [31:0] mk(input logic [1:0] v, input logic [4:0] rm,
                                     input logic [1:0] sh, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {8'b00000100, v, 1'b1, rm, 4'b1010, sh, rn, rd};
  endfunction

  function automatic bit recognised(input logic [31:0] w);
    return (w[31:24] == 8'd4) && w[21] && (w[15:12] == 4'd10);
  endfunction

  // lane-by-lane arithmetic written from the requirements
  function automatic logic [VW-1:0] refAddr(input logic [31:0] w,
                                            input logic [VW-1:0] a,
                                            input logic [VW-1:0] b);
    logic [VW-1:0] r;
    int sh;
    sh = int'(w[11:10]);
    r = '0;
    if (w[23:22] == 2'b10) begin
      for (int i = 0; i < VW/32; i++) begin
        longint unsigned s;
        s = longint'(a[i*32 +: 32]) + (longint'(b[i*32 +: 32]) * (64'd1 << sh));
        r[i*32 +: 32] = s[31:0];
      end
    end else begin
      for (int i = 0; i < VW/64; i++) begin
        longint unsigned o;
        case (w[23:22])
          2'b00: o = longint'($signed(b[i*64 +: 32]));
          2'b01: o = {32'b0, b[i*64 +: 32]};
          default: o = b[i*64 +: 64];
        endcase
        r[i*64 +: 64] = a[i*64 +: 64] + o * (64'd1 << sh);
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] x;
    for (int i = 0; i < VW/32; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (outValid !== expValid || outIllegal !== expIll) begin
      errors++;
      $display("FAIL %s flags: got valid=%b illegal=%b, expected valid=%b illegal=%b",
               tag, outValid, outIllegal, expValid, expIll);
    end
    if (haveData) begin
      checks++;
      if (outVec !== expVec || outRd !== expRd || outRn !== expRn || outRm !== expRm) begin
        errors++;
        $display("FAIL %s data: got vec=%h rd=%0d rn=%0d rm=%0d, expected vec=%h rd=%0d rn=%0d rm=%0d",
                 tag, outVec, outRd, outRn, outRm, expVec, expRd, expRn, expRm);
      end
    end
  endtask

  // drive one cycle of input at the falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [31:0] w, input logic [VW-1:0] a,
                      input logic [VW-1:0] b, input string tag);
    inValid = v; instr = w; baseVec = a; offsVec = b;
    if (v && recognised(w)) begin
      expValid = 1; expIll = 0; haveData = 1;
      expVec = refAddr(w, a, b);
      expRd = w[4:0]; expRn = w[9:5]; expRm = w[20:16];
    end else begin
      expValid = 0; expIll = v;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [VW-1:0] ones;
    ones = '1;
    expValid = 0; expIll = 0; haveData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11");   // reset state
    rst = 0;

    // R5 and R8: 64-bit lanes, every scale, top bits discarded
    for (int s = 0; s < 4; s++)
      step(1, mk(2'b11, 5'd3, s[1:0], 5'd7, 5'd9), rnd(), rnd(), "R5");
    step(1, mk(2'b11, 5'd1, 2'd3, 5'd2, 5'd3), '0, ones, "R8");

    // R4: 32-bit lanes, carries stay inside each lane
    step(1, mk(2'b10, 5'd4, 2'd0, 5'd5, 5'd6), ones, {(VW/32){32'd1}}, "R4");
    step(1, mk(2'b10, 5'd4, 2'd2, 5'd5, 5'd6), rnd(), rnd(), "R4");

    // R6: sign extension, upper offset half ignored
    step(1, mk(2'b00, 5'd8, 2'd1, 5'd9, 5'd10), rnd(), {(VW/64){32'hDEADBEEF, 32'h80000000}}, "R6");
    step(1, mk(2'b00, 5'd8, 2'd3, 5'd9, 5'd10), rnd(), rnd(), "R6");

    // R7: zero extension
    step(1, mk(2'b01, 5'd11, 2'd2, 5'd12, 5'd13), rnd(), {(VW/64){32'hFFFFFFFF, 32'hFFFFFFFF}}, "R7");

    // R2 and R9: back-to-back mode switches
    step(1, mk(2'b10, 5'd1, 2'd1, 5'd2, 5'd3), rnd(), rnd(), "R2");
    step(1, mk(2'b00, 5'd4, 2'd1, 5'd5, 5'd6), rnd(), rnd(), "R9");
    step(1, mk(2'b11, 5'd7, 2'd1, 5'd8, 5'd9), rnd(), rnd(), "R9");

    // R3: register numbers at their extremes
    step(1, mk(2'b01, 5'd31, 2'd0, 5'd0, 5'd31), rnd(), rnd(), "R3");
    step(1, mk(2'b01, 5'd0, 2'd0, 5'd31, 5'd0), rnd(), rnd(), "R3");

    // R1 and R10: each match field disturbed, data must hold
    step(1, mk(2'b11, 5'd1, 2'd0, 5'd1, 5'd1) & ~32'h0020_0000, rnd(), rnd(), "R1");
    step(1, mk(2'b11, 5'd1, 2'd0, 5'd1, 5'd1) ^ 32'h0100_0000, rnd(), rnd(), "R1");
    step(1, mk(2'b11, 5'd1, 2'd0, 5'd1, 5'd1) ^ 32'h0000_1000, rnd(), rnd(), "R10");
    step(1, mk(2'b10, 5'd2, 2'd0, 5'd2, 5'd2), rnd(), rnd(), "R10");

    // R12: idle cycles, including one with a recognised word present
    step(0, mk(2'b11, 5'd5, 2'd1, 5'd5, 5'd5), rnd(), rnd(), "R12");
    step(0, 32'h0, rnd(), rnd(), "R12");

    // reset in the middle clears flags
    step(1, mk(2'b11, 5'd3, 2'd1, 5'd3, 5'd3), rnd(), rnd(), "R9");
    rst = 1;
    inValid = 1; instr = mk(2'b11, 5'd3, 2'd1, 5'd3, 5'd3);
    @(posedge clk);
    @(negedge clk);
    rst = 0; inValid = 0;
    expValid = 0; expIll = 0; haveData = 0;
    check("R11");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] w;
      w = ($urandom % 5 == 0) ? $urandom
                               : mk(2'($urandom), 5'($urandom), 2'($urandom), 5'($urandom), 5'($urandom));
      step(($urandom % 6) != 0, w, rnd(), rnd(), "R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule